// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking an in-memory translation table of up to two levels. The virtual address space is split in two: the lowest gigabyte belongs to the running process and is walked from a per-process table base, while everything from one gigabyte upward belongs to the kernel and is walked from a separate, long-lived kernel table base. Because the two bases are independent, a process switch only needs the process base to be reloaded.

A walk reads the first-level descriptor, which maps a whole megabyte directly or points to a second-level table. In the second case, the walker reads a second-level descriptor that maps a 4 KB page. Descriptors come in over a simple read port that carries one request at a time. The result is either a physical address with its cache, access and domain attributes, or a five-bit fault status. Sixteen-megabyte and 64 KB mapping formats are not translated. They are reported as an unsupported-format fault.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `res_valid` and `mem_rd_valid` are 0.
- R2: If bits [31:30] of the virtual address are 00, the process base is used; otherwise the kernel base is used. The first read goes to {base[31:14], va[31:20], 2'b00}.
- R3: A first-level descriptor with bits [1:0] = 10 and bit 18 = 0 is a section. The result is paddr = {d[31:20], va[19:0]}, cb = d[3:2], domain = d[8:5] and ap = d[11:10], with fault 0 and fault status 0. No second read is made.
- R4: A first-level descriptor with bits [1:0] = 01 is a table pointer. The second read goes to {d[31:10], va[19:12], 2'b00}.
- R5: A second-level descriptor with bit 1 = 1 is a small page. The result is paddr = {d[31:12], va[11:0]}, cb = d[3:2], ap = d[5:4], and the domain taken from bits [8:5] of the first-level pointer.
- R6: First-level type 00 or 11 gives fault status 5'b00101 after a single read.
- R7: Second-level type 00 gives fault status 5'b00111.
- R8: A first-level section with bit 18 set, or second-level type 01, gives fault status 5'b11000. On every fault, paddr, cb, ap and domain are 0.
- R9: At most one read is outstanding at a time. `mem_rd_valid` stays high with a stable address until `mem_rd_ready` is seen. `mem_rsp_valid` is ignored unless the walker is waiting for a response.
- R10: `req_ready` is high only when the walker is idle. A request presented while a walk is in progress is ignored and does not start a later walk.
- R11: `res_valid` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| proc_base | input | 32 | Process table base (low gigabyte) |
| kern_base | input | 32 | Kernel table base (upper three gigabytes) |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Read request taken by memory |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk ended in a fault |
| res_fstat | output | 5 | Fault status, 0 on success |
| res_paddr | output | 32 | Physical address |
| res_cb | output | 2 | Cacheable/bufferable attributes |
| res_ap | output | 2 | Access permission bits |
| res_domain | output | 4 | Domain number |

## Verification
The vector table walks the address space on both sides of the one-gigabyte split, including the last process megabyte and the first kernel address. This shows that the base is chosen from the address and not from some fixed table. Each descriptor format is used at least once: section, pointer followed by small page (both small-page type codes), empty entries at either level, type 11 at the first level, supersection and large page. Together these separate every decode arm and every fault code. The memory responder varies its accept stall and data latency from vector to vector, which shows that the handshake timing does not change the result. Directed cases hold a second request high during a walk and drive a stray read response while idle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned AW = 32;
    localparam int unsigned SUPER_BIT = 18;

    localparam logic [4:0] FS_NONE      = 5'b00000;
    localparam logic [4:0] FS_SECT_XLAT = 5'b00101;
    localparam logic [4:0] FS_PAGE_XLAT = 5'b00111;
    localparam logic [4:0] FS_UNSUP     = 5'b11000;

    typedef enum logic [2:0] {
        W_IDLE, W_L1_REQ, W_L1_WAIT, W_L2_REQ, W_L2_WAIT, W_DONE
    } walk_st_e;

    typedef enum logic [1:0] {L1_FAULT, L1_TABLE, L1_SECT, L1_UNSUP} l1_kind_e;
    typedef enum logic [1:0] {L2_FAULT, L2_SMALL, L2_UNSUP} l2_kind_e;

    typedef struct packed {
        logic [AW-1:0] pa;
        logic          fault;
        logic [4:0]    fs;
        logic [1:0]    cb;
        logic [1:0]    ap;
        logic [3:0]    dom;
    } walk_res_t;
endpackage

// File: rtl/ptw_base_sel.sv
module ptw_base_sel
    import ptw_pkg::*;
#(
    parameter int unsigned L1_IDX_W   = 12,
    parameter int unsigned PROC_TOP_W = 2
) (
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] proc_base,
    input  logic [AW-1:0] kern_base,
    output logic [AW-1:0] l1_addr
);
    localparam int unsigned BASE_LO = L1_IDX_W + 2;

    logic          in_proc;
    logic [AW-1:0] base;
    logic          unused_base;

    // Upper address bits all zero selects the process region.
    assign in_proc = (vaddr[AW-1 -: PROC_TOP_W] == '0);
    assign base    = in_proc ? proc_base : kern_base;
    assign l1_addr = {base[AW-1:BASE_LO], vaddr[AW-1 -: L1_IDX_W], 2'b00};
    assign unused_base = ^{base[BASE_LO-1:0], vaddr[AW-L1_IDX_W-1:0]};
endmodule

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
    import ptw_pkg::*;
#(
    parameter int unsigned L1_IDX_W = 12,
    parameter int unsigned L2_IDX_W = 8
) (
    input  logic [AW-1:0]          desc,
    input  logic [AW-L1_IDX_W-1:0] va_lo,
    output l1_kind_e               kind,
    output logic [AW-1:0]          sect_pa,
    output logic [AW-1:0]          l2_addr,
    output logic [1:0]             cb,
    output logic [1:0]             ap,
    output logic [3:0]             dom
);
    localparam int unsigned SECT_W = AW - L1_IDX_W;
    localparam int unsigned PG_W   = SECT_W - L2_IDX_W;
    localparam int unsigned L2B_LO = L2_IDX_W + 2;

    logic unused_desc;

    always_comb begin
        unique case (desc[1:0])
            2'b01:   kind = L1_TABLE;
            2'b10:   kind = desc[SUPER_BIT] ? L1_UNSUP : L1_SECT;
            default: kind = L1_FAULT;
        endcase
    end

    assign sect_pa = {desc[AW-1 -: L1_IDX_W], va_lo};
    assign l2_addr = {desc[AW-1:L2B_LO], va_lo[PG_W +: L2_IDX_W], 2'b00};
    assign cb      = desc[3:2];
    assign dom     = desc[8:5];
    assign ap      = desc[11:10];
    assign unused_desc = ^{desc[4], desc[9]};
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
    import ptw_pkg::*;
#(
    parameter int unsigned PG_W = 12
) (
    input  logic [AW-1:0]   desc,
    input  logic [PG_W-1:0] va_off,
    output l2_kind_e        kind,
    output logic [AW-1:0]   pa,
    output logic [1:0]      cb,
    output logic [1:0]      ap
);
    logic unused_desc;

    always_comb begin
        if (desc[1])               kind = L2_SMALL;
        else if (desc[0])          kind = L2_UNSUP;
        else                       kind = L2_FAULT;
    end

    assign pa = {desc[AW-1:PG_W], va_off};
    assign cb = desc[3:2];
    assign ap = desc[5:4];
    assign unused_desc = ^desc[PG_W-1:6];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int unsigned L1_IDX_W   = 12,
    parameter int unsigned L2_IDX_W   = 8,
    parameter int unsigned PROC_TOP_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_vaddr,
    input  logic [31:0]   proc_base,
    input  logic [31:0]   kern_base,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [31:0]   mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          res_valid,
    output logic          res_fault,
    output logic [4:0]    res_fstat,
    output logic [31:0]   res_paddr,
    output logic [1:0]    res_cb,
    output logic [1:0]    res_ap,
    output logic [3:0]    res_domain
);
    localparam int unsigned SECT_W = AW - L1_IDX_W;
    localparam int unsigned PG_W   = SECT_W - L2_IDX_W;

    typedef struct packed {
        walk_st_e      st;
        logic [AW-1:0] va;
        logic [AW-1:0] addr;
        logic [3:0]    dom;
        walk_res_t     res;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [AW-1:0] l1_addr;
    l1_kind_e      l1_kind;
    logic [AW-1:0] l1_pa, l2_addr;
    logic [1:0]    l1_cb, l1_ap;
    logic [3:0]    l1_dom;
    l2_kind_e      l2_kind;
    logic [AW-1:0] l2_pa;
    logic [1:0]    l2_cb, l2_ap;

    ptw_base_sel #(.L1_IDX_W(L1_IDX_W), .PROC_TOP_W(PROC_TOP_W)) u_base (
        .vaddr(req_vaddr), .proc_base(proc_base), .kern_base(kern_base),
        .l1_addr(l1_addr)
    );

    ptw_l1_dec #(.L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)) u_l1 (
        .desc(mem_rsp_data), .va_lo(r_q.va[SECT_W-1:0]), .kind(l1_kind),
        .sect_pa(l1_pa), .l2_addr(l2_addr), .cb(l1_cb), .ap(l1_ap), .dom(l1_dom)
    );

    ptw_l2_dec #(.PG_W(PG_W)) u_l2 (
        .desc(mem_rsp_data), .va_off(r_q.va[PG_W-1:0]), .kind(l2_kind),
        .pa(l2_pa), .cb(l2_cb), .ap(l2_ap)
    );

    function automatic walk_res_t fault_res(input logic [4:0] code);
        walk_res_t f;
        f       = '0;
        f.fault = 1'b1;
        f.fs    = code;
        return f;
    endfunction

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            W_IDLE: begin
                if (req_valid) begin
                    r_d.va   = req_vaddr;
                    r_d.addr = l1_addr;
                    r_d.st   = W_L1_REQ;
                end
            end
            W_L1_REQ: if (mem_rd_ready) r_d.st = W_L1_WAIT;
            W_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (l1_kind)
                        L1_SECT: begin
                            r_d.res = '{pa: l1_pa, fault: 1'b0, fs: FS_NONE,
                                        cb: l1_cb, ap: l1_ap, dom: l1_dom};
                            r_d.st  = W_DONE;
                        end
                        L1_TABLE: begin
                            r_d.addr = l2_addr;
                            r_d.dom  = l1_dom;
                            r_d.st   = W_L2_REQ;
                        end
                        L1_UNSUP: begin
                            r_d.res = fault_res(FS_UNSUP);
                            r_d.st  = W_DONE;
                        end
                        default: begin
                            r_d.res = fault_res(FS_SECT_XLAT);
                            r_d.st  = W_DONE;
                        end
                    endcase
                end
            end
            W_L2_REQ: if (mem_rd_ready) r_d.st = W_L2_WAIT;
            W_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (l2_kind)
                        L2_SMALL: r_d.res = '{pa: l2_pa, fault: 1'b0, fs: FS_NONE,
                                              cb: l2_cb, ap: l2_ap, dom: r_q.dom};
                        L2_UNSUP: r_d.res = fault_res(FS_UNSUP);
                        default:  r_d.res = fault_res(FS_PAGE_XLAT);
                    endcase
                    r_d.st = W_DONE;
                end
            end
            W_DONE:  r_d.st = W_IDLE;
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= W_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.st == W_IDLE);
    assign mem_rd_valid = (r_q.st == W_L1_REQ) || (r_q.st == W_L2_REQ);
    assign mem_rd_addr  = r_q.addr;
    assign res_valid    = (r_q.st == W_DONE);
    assign res_fault    = r_q.res.fault;
    assign res_fstat    = r_q.res.fs;
    assign res_paddr    = r_q.res.pa;
    assign res_cb       = r_q.res.cb;
    assign res_ap       = r_q.res.ap;
    assign res_domain   = r_q.res.dom;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        res_valid,
    input logic        res_fault,
    input logic [4:0]  res_fstat,
    input logic [31:0] res_paddr,
    input logic [1:0]  res_cb,
    input logic [1:0]  res_ap,
    input logic [3:0]  res_domain
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R9
    AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00); // R2
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready); // R10
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R10
    AST_RES_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready && !mem_rd_valid); // R10
    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R11
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> res_paddr == '0 && res_cb == '0 && res_ap == '0 && res_domain == '0); // R8
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> res_fstat == 5'b00101 || res_fstat == 5'b00111 || res_fstat == 5'b11000); // R6
    AST_OK_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_fault |-> res_fstat == 5'b00000); // R3
endmodule

bind pt_walker ptw_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .res_valid(res_valid), .res_fault(res_fault), .res_fstat(res_fstat),
    .res_paddr(res_paddr), .res_cb(res_cb), .res_ap(res_ap), .res_domain(res_domain)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    localparam logic [31:0] PBASE = 32'h0001_0000;
    localparam logic [31:0] KBASE = 32'h0002_C000;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] l1d;
        logic [31:0] l2d;
        logic [1:0]  nrd;
        logic        flt;
        logic [4:0]  fs;
        logic [31:0] pa;
        logic [1:0]  cb;
        logic [1:0]  ap;
        logic [3:0]  dom;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0012_3456, 32'h8050_0C6A, 32'h0,         2'd1, 1'b0, 5'b00000, 32'h8052_3456, 2'd2, 2'd3, 4'd3, 4'd3},
        '{32'h4567_89AB, 32'h0030_04A1, 32'h1234_5016, 2'd2, 1'b0, 5'b00000, 32'h1234_59AB, 2'd1, 2'd1, 4'd5, 4'd5},
        '{32'h3FFF_F000, 32'h0000_0000, 32'h0,         2'd1, 1'b1, 5'b00101, 32'h0,         2'd0, 2'd0, 4'd0, 4'd6},
        '{32'h4000_0000, 32'hABC0_0402, 32'h0,         2'd1, 1'b0, 5'b00000, 32'hABC0_0000, 2'd0, 2'd1, 4'd0, 4'd3},
        '{32'hC010_0000, 32'h0104_0002, 32'h0,         2'd1, 1'b1, 5'b11000, 32'h0,         2'd0, 2'd0, 4'd0, 4'd8},
        '{32'h0020_1000, 32'h0020_0801, 32'h0000_0000, 2'd2, 1'b1, 5'b00111, 32'h0,         2'd0, 2'd0, 4'd0, 4'd7},
        '{32'h8000_3000, 32'h0040_0001, 32'h5555_0001, 2'd2, 1'b1, 5'b11000, 32'h0,         2'd0, 2'd0, 4'd0, 4'd8},
        '{32'hFFF0_0ABC, 32'h1234_5673, 32'h0,         2'd1, 1'b1, 5'b00101, 32'h0,         2'd0, 2'd0, 4'd0, 4'd6},
        '{32'h0000_1234, 32'h0050_0001, 32'hFEDC_B033, 2'd2, 1'b0, 5'b00000, 32'hFEDC_B234, 2'd0, 2'd3, 4'd0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] proc_base = PBASE;
    logic [31:0] kern_base = KBASE;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid, res_fault;
    logic [4:0]  res_fstat;
    logic [31:0] res_paddr;
    logic [1:0]  res_cb, res_ap;
    logic [3:0]  res_domain;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int          stall = 0;
    int          lat = 0;
    int          nrd = 0;
    logic [31:0] rd_log [4];
    logic [31:0] m_a1, m_d1, m_a2, m_d2;

    logic        g_flt;
    logic [4:0]  g_fs;
    logic [31:0] g_pa;
    logic [1:0]  g_cb, g_ap;
    logic [3:0]  g_dom;

    always #10 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .proc_base(proc_base), .kern_base(kern_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_fstat(res_fstat),
        .res_paddr(res_paddr), .res_cb(res_cb), .res_ap(res_ap), .res_domain(res_domain)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string tag_name(input int k);
        case (k)
            3: return "R3";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R?";
        endcase
    endfunction

    function automatic logic [31:0] mem_lookup(input logic [31:0] a);
        if (a == m_a1) return m_d1;
        if (a == m_a2) return m_d2;
        return 32'hDEAD_0000;
    endfunction

    // Memory responder: stall before accepting, then return data after a latency.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                logic [31:0] a0;
                a0 = mem_rd_addr;
                repeat (stall) @(negedge clk);
                if (stall > 0)
                    chk(mem_rd_valid && mem_rd_addr == a0, "R9", "read held while stalled",
                        mem_rd_addr, a0);
                mem_rd_ready = 1'b1;
                if (nrd < 4) rd_log[nrd] = mem_rd_addr;
                nrd++;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_lookup(rd_log[(nrd - 1) % 4]);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input bit hold, input logic [31:0] other);
        int cnt;
        @(negedge clk);
        nrd       = 0;
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        if (hold) req_vaddr = other;
        else      req_valid = 1'b0;
        cnt = 0;
        while (!res_valid && cnt < 300) begin
            @(negedge clk);
            cnt++;
        end
        g_flt = res_fault; g_fs = res_fstat; g_pa = res_paddr;
        g_cb = res_cb; g_ap = res_ap; g_dom = res_domain;
        chk(res_valid, "R11", "result arrived", {31'b0, res_valid}, 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!res_valid, "R11", "result is one cycle", {31'b0, res_valid}, 32'd0);
    endtask

    function automatic logic [31:0] l1_of(input logic [31:0] va);
        logic [31:0] b;
        b = (va[31:30] == 2'b00) ? PBASE : KBASE;
        return {b[31:14], va[31:20], 2'b00};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready in reset", {31'b0, req_ready}, 32'd1);
        chk(res_valid == 1'b0, "R1", "res_valid in reset", {31'b0, res_valid}, 32'd0);
        chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid in reset", {31'b0, mem_rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v     = VECS[i];
            t     = tag_name(int'(v.tag));
            stall = i % 3;
            lat   = i % 2;
            m_a1  = l1_of(v.va);
            m_d1  = v.l1d;
            m_a2  = {v.l1d[31:10], v.va[19:12], 2'b00};
            m_d2  = v.l2d;
            run_walk(v.va, 1'b0, '0);
            chk(nrd == int'(v.nrd), t, "descriptor reads", nrd, {30'b0, v.nrd});
            chk(rd_log[0] == m_a1, "R2", "first-level address", rd_log[0], m_a1);
            if (v.nrd == 2'd2)
                chk(rd_log[1] == m_a2, "R4", "second-level address", rd_log[1], m_a2);
            chk(g_flt == v.flt, t, "fault flag", {31'b0, g_flt}, {31'b0, v.flt});
            chk(g_fs == v.fs, t, "fault status", {27'b0, g_fs}, {27'b0, v.fs});
            chk(g_pa == v.pa, t, "physical address", g_pa, v.pa);
            chk({g_cb, g_ap, g_dom} == {v.cb, v.ap, v.dom}, t, "cb/ap/domain",
                {24'b0, g_cb, g_ap, g_dom}, {24'b0, v.cb, v.ap, v.dom});
        end

        // R10: second request held during a walk is ignored and starts nothing.
        stall = 1; lat = 1;
        m_a1 = l1_of(VECS[1].va); m_d1 = VECS[1].l1d;
        m_a2 = {VECS[1].l1d[31:10], VECS[1].va[19:12], 2'b00}; m_d2 = VECS[1].l2d;
        run_walk(VECS[1].va, 1'b1, VECS[0].va);
        chk(g_pa == VECS[1].pa, "R10", "busy request ignored", g_pa, VECS[1].pa);
        repeat (4) @(negedge clk);
        chk(nrd == 2, "R10", "no walk from busy request", nrd, 32'd2);
        chk(req_ready && !mem_rd_valid, "R10", "idle after walk",
            {31'b0, req_ready}, 32'd1);

        // R9: a stray response while idle produces nothing.
        @(negedge clk);
        mem_rsp_data  = VECS[0].l1d;
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        chk(!res_valid && !mem_rd_valid, "R9", "stray response ignored",
            {31'b0, res_valid}, 32'd0);
        mem_rsp_valid = 1'b0;
        @(negedge clk);
        chk(!res_valid && req_ready, "R9", "still idle after stray response",
            {31'b0, req_ready}, 32'd1);

        // R3 again with zero stall and latency on the first kernel address.
        stall = 0; lat = 0;
        m_a1 = l1_of(VECS[3].va); m_d1 = VECS[3].l1d; m_a2 = '1; m_d2 = '0;
        run_walk(VECS[3].va, 1'b0, '0);
        chk(g_pa == VECS[3].pa && !g_flt, "R3", "section, no stalls", g_pa, VECS[3].pa);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule